// File: doc/BRIEF.md
# Scoreboarded Warp Issue Scheduler

The block holds the context of up to sixteen warps and, every cycle, picks at most one of them to issue its next instruction. For each warp it keeps four things: whether it is running, a per-register pending-write scoreboard, a count of cycles spent waiting since its last issue, and the operand fields of the warp's next instruction. Those fields are the two source registers, the destination register and a kind code. A fetch stub loads the operand fields through a load port. An execution stub returns completed writes through a writeback port.

A warp may issue only when all of the following hold: it is running, it holds an instruction, it is not held at a barrier, and neither of its source registers is pending. Among the warps that may issue, the one that has waited longest wins. When several warps have the same waiting count, a round-robin pointer breaks the tie. A barrier instruction parks its warp until every running warp of the same thread block has also reached the barrier. An exit instruction retires its warp.

Top module: `warp_sched`

## Requirements
- R1: After reset no warp is running and `issue_valid` is low. A load to a warp that has not been launched never produces an issue.
- R2: A launch marks the warp running and sets its block id. It clears the warp's scoreboard, waiting count, barrier hold and held instruction, so a freshly launched warp does not issue until an instruction is loaded.
- R3: A warp may issue only if it is running, holds an instruction, is not held at a barrier, and neither `src_a` nor `src_b` of that instruction is pending.
- R4: Issuing kind 0 (register write) marks the destination register pending from the next cycle on. A writeback for that warp and register clears the bit from the next cycle on. When an issue and a writeback hit the same bit in the same cycle, the bit ends up set.
- R5: At most one warp issues per cycle. `issue_valid` is high exactly when some warp may issue.
- R6: The winner has the largest waiting count among the warps that may issue.
- R7: Among warps with equal waiting counts, the winner is the first one met when counting upward, with wrap-around, from the warp after the previous winner. The count starts at warp 0 after reset.
- R8: The waiting count of a running warp rises by one each cycle it does not issue and saturates at its maximum. It returns to zero on the cycle after the warp issues.
- R9: Issuing kind 2 (barrier) holds the warp. All held warps of a block are released together, one cycle after the cycle in which every running warp of that block is held.
- R10: Issuing kind 3 (exit) makes the warp not running. Kind 1 writes no register.
- R11: Issuing clears the warp's held instruction. A load to the same warp in the issuing cycle leaves the new instruction held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_valid | input | 1 | Launch a warp |
| launch_warp | input | 4 | Warp to launch |
| launch_block | input | 2 | Thread block id of the launched warp |
| ld_valid | input | 1 | Load next-instruction fields |
| ld_warp | input | 4 | Warp receiving the instruction |
| ld_src_a | input | 4 | First source register |
| ld_src_b | input | 4 | Second source register |
| ld_dst | input | 4 | Destination register |
| ld_kind | input | 2 | 0 write, 1 no write, 2 barrier, 3 exit |
| wb_valid | input | 1 | Completed register write |
| wb_warp | input | 4 | Warp of the completed write |
| wb_reg | input | 4 | Register of the completed write |
| issue_valid | output | 1 | A warp issues this cycle |
| issue_warp | output | 4 | Issuing warp |
| issue_kind | output | 2 | Kind of the issued instruction |
| issue_dst | output | 4 | Destination of the issued instruction |

## Verification
Several input patterns are used, and each one separates a different piece of the selection logic. Two warps released together from a barrier after arriving at different times have different waiting counts, so the pair shows whether age decides. Four warps saturated by a long idle spell have equal counts, so the release order they produce shows whether the round-robin pointer decides, rather than warp index. Dependent instructions show that the scoreboard stalls without a bypass. A writeback in the same cycle as a re-issue to the same register shows that the set wins. A long random run with launches, exits, barriers and out-of-order writebacks is compared every cycle against a behavioural model.

// File: rtl/warp_sched.sv
module warp_sched #(
  parameter int NW    = 16,   // warps, power of two
  parameter int NR    = 16,   // registers tracked per warp, power of two
  parameter int AGE_W = 8,
  parameter int BLK_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     launch_valid,
  input  logic [$clog2(NW)-1:0]    launch_warp,
  input  logic [BLK_W-1:0]         launch_block,
  input  logic                     ld_valid,
  input  logic [$clog2(NW)-1:0]    ld_warp,
  input  logic [$clog2(NR)-1:0]    ld_src_a,
  input  logic [$clog2(NR)-1:0]    ld_src_b,
  input  logic [$clog2(NR)-1:0]    ld_dst,
  input  logic [1:0]               ld_kind,
  input  logic                     wb_valid,
  input  logic [$clog2(NW)-1:0]    wb_warp,
  input  logic [$clog2(NR)-1:0]    wb_reg,
  output logic                     issue_valid,
  output logic [$clog2(NW)-1:0]    issue_warp,
  output logic [1:0]               issue_kind,
  output logic [$clog2(NR)-1:0]    issue_dst
);
  localparam int WW = $clog2(NW);
  localparam int RW = $clog2(NR);
  localparam int KW = AGE_W + WW;
  localparam logic [1:0] K_WR = 2'd0, K_BAR = 2'd2, K_EXIT = 2'd3;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic             act   [NW];
  logic             has_i [NW];
  logic             bar   [NW];
  logic             rel   [NW];
  logic [NR-1:0]    pend  [NW];
  logic [AGE_W-1:0] age   [NW];
  logic [BLK_W-1:0] blk   [NW];
  logic [RW-1:0]    sa    [NW];
  logic [RW-1:0]    sb    [NW];
  logic [RW-1:0]    dst   [NW];
  logic [1:0]       kind  [NW];

  logic [NW-1:0]       elig, act_v, bar_v;
  logic [NW*NR-1:0]    pend_flat;
  logic [NW*AGE_W-1:0] age_flat;
  logic [WW-1:0]       rr, sel;
  logic                sel_v;
  logic [KW-1:0]       best, key;

  always_comb begin
    sel_v = 1'b0;
    sel   = '0;
    best  = '0;
    key   = '0;
    for (int i = 0; i < NW; i++) begin
      key = {age[i], WW'(NW-1) - (WW'(i) - rr)};
      if (elig[i] && (!sel_v || key > best)) begin
        sel_v = 1'b1;
        sel   = WW'(i);
        best  = key;
      end
    end
  end

  assign issue_valid = sel_v;
  assign issue_warp  = sel;
  assign issue_kind  = kind[sel];
  assign issue_dst   = dst[sel];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     rr <= '0;
    else if (sel_v) rr <= sel + 1'b1;

  for (genvar g = 0; g < NW; g++) begin : g_warp
    wire win = sel_v && (sel == WW'(g));

    assign elig[g]  = act[g] & has_i[g] & ~bar[g] & ~pend[g][sa[g]] & ~pend[g][sb[g]];
    assign act_v[g] = act[g];
    assign bar_v[g] = bar[g];
    assign pend_flat[g*NR +: NR]      = pend[g];
    assign age_flat[g*AGE_W +: AGE_W] = age[g];

    always_comb begin
      rel[g] = act[g] & bar[g];
      for (int j = 0; j < NW; j++)
        if (act[j] && !bar[j] && blk[j] == blk[g]) rel[g] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act[g]   <= 1'b0;
        has_i[g] <= 1'b0;
        bar[g]   <= 1'b0;
        pend[g]  <= '0;
        age[g]   <= '0;
        blk[g]   <= '0;
        sa[g]    <= '0;
        sb[g]    <= '0;
        dst[g]   <= '0;
        kind[g]  <= '0;
      end else begin
        if (launch_valid && launch_warp == WW'(g)) begin
          act[g]   <= 1'b1;
          blk[g]   <= launch_block;
          pend[g]  <= '0;
          age[g]   <= '0;
          bar[g]   <= 1'b0;
          has_i[g] <= 1'b0;
        end else begin
          if (wb_valid && wb_warp == WW'(g)) pend[g][wb_reg] <= 1'b0;
          if (act[g]) begin
            if (win) begin
              age[g]   <= '0;
              has_i[g] <= 1'b0;
              case (kind[g])
                K_WR:    pend[g][dst[g]] <= 1'b1;
                K_BAR:   bar[g] <= 1'b1;
                K_EXIT:  act[g] <= 1'b0;
                default: ;
              endcase
            end else if (age[g] != AGE_MAX) begin
              age[g] <= age[g] + 1'b1;
            end
            if (rel[g]) bar[g] <= 1'b0;
          end
        end
        if (ld_valid && ld_warp == WW'(g)) begin
          has_i[g] <= 1'b1;
          sa[g]    <= ld_src_a;
          sb[g]    <= ld_src_b;
          dst[g]   <= ld_dst;
          kind[g]  <= ld_kind;
        end
      end
    end
  end
endmodule

// File: rtl/warp_sched_chk.sv
module warp_sched_chk #(
  parameter int NW    = 16,
  parameter int NR    = 16,
  parameter int AGE_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     launch_valid,
  input logic [$clog2(NW)-1:0]    launch_warp,
  input logic                     issue_valid,
  input logic [$clog2(NW)-1:0]    issue_warp,
  input logic [1:0]               issue_kind,
  input logic [$clog2(NR)-1:0]    issue_dst,
  input logic [NW-1:0]            elig_vec,
  input logic [NW-1:0]            act_vec,
  input logic [NW-1:0]            bar_vec,
  input logic [NW*NR-1:0]         pend_flat,
  input logic [NW*AGE_W-1:0]      age_flat
);
  localparam int WW = $clog2(NW);
  localparam int RW = $clog2(NR);

  logic [WW-1:0] last_w;
  logic [RW-1:0] last_d;
  logic          older;

  always_ff @(posedge clk) begin
    last_w <= issue_warp;
    last_d <= issue_dst;
  end

  always_comb begin
    older = 1'b0;
    for (int i = 0; i < NW; i++)
      if (elig_vec[i] && age_flat[i*AGE_W +: AGE_W] > age_flat[issue_warp*AGE_W +: AGE_W])
        older = 1'b1;
  end

  AST_ISSUE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> act_vec[issue_warp] && !bar_vec[issue_warp]); // R3
  AST_IDLE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_vec == '0) |-> !issue_valid); // R5
  AST_ISSUE_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_vec != '0) |-> issue_valid); // R5
  AST_OLDEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> !older); // R6
  AST_DST_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && issue_kind == 2'd0 && !(launch_valid && launch_warp == issue_warp)
    |=> pend_flat[{last_w, last_d}]); // R4
  AST_AGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> age_flat[last_w*AGE_W +: AGE_W] == '0); // R8
  AST_ONE_HOT_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> $countones(elig_vec) >= 1); // R5
endmodule

bind warp_sched warp_sched_chk #(.NW(NW), .NR(NR), .AGE_W(AGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .launch_valid(launch_valid), .launch_warp(launch_warp),
  .issue_valid(issue_valid), .issue_warp(issue_warp),
  .issue_kind(issue_kind), .issue_dst(issue_dst),
  .elig_vec(elig), .act_vec(act_v), .bar_vec(bar_v),
  .pend_flat(pend_flat), .age_flat(age_flat)
);

// File: tb/tb_warp_sched.sv
`timescale 1ns/1ps
module tb_warp_sched;
  localparam int NW = 16, NR = 16, AGE_W = 8, BLK_W = 2;
  localparam int AGE_MAX = (1 << AGE_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic launch_valid = 0; logic [3:0] launch_warp = 0; logic [1:0] launch_block = 0;
  logic ld_valid = 0; logic [3:0] ld_warp = 0, ld_src_a = 0, ld_src_b = 0, ld_dst = 0; logic [1:0] ld_kind = 0;
  logic wb_valid = 0; logic [3:0] wb_warp = 0, wb_reg = 0;
  logic issue_valid; logic [3:0] issue_warp; logic [1:0] issue_kind; logic [3:0] issue_dst;

  warp_sched #(.NW(NW), .NR(NR), .AGE_W(AGE_W), .BLK_W(BLK_W)) dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  bit m_act[NW], m_has[NW], m_bar[NW], m_pend[NW][NR];
  int m_age[NW], m_blk[NW], m_sa[NW], m_sb[NW], m_dst[NW], m_kind[NW];
  int m_rr = 0;
  int q_w[$], q_r[$];

  task automatic chk(bit ok, string req, string what, int a, int e);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, a, e);
    end
  endtask

  function automatic bit m_ready(int i);
    return m_act[i] && m_has[i] && !m_bar[i] && !m_pend[i][m_sa[i]] && !m_pend[i][m_sb[i]];
  endfunction

  function automatic void model_pick(output bit v, output int w);
    int best = -1;
    v = 0; w = 0;
    for (int k = 0; k < NW; k++) begin
      int idx = (m_rr + k) % NW;
      if (m_ready(idx) && m_age[idx] > best) begin best = m_age[idx]; w = idx; v = 1; end
    end
  endfunction

  task automatic model_update(bit ev, int ew);
    bit rl[NW];
    for (int i = 0; i < NW; i++) begin
      rl[i] = m_act[i] && m_bar[i];
      for (int j = 0; j < NW; j++)
        if (m_act[j] && !m_bar[j] && m_blk[j] == m_blk[i]) rl[i] = 0;
    end
    for (int i = 0; i < NW; i++) begin
      if (launch_valid && int'(launch_warp) == i) begin
        m_act[i] = 1; m_blk[i] = int'(launch_block); m_age[i] = 0; m_bar[i] = 0; m_has[i] = 0;
        for (int r = 0; r < NR; r++) m_pend[i][r] = 0;
      end else begin
        if (wb_valid && int'(wb_warp) == i) m_pend[i][wb_reg] = 0;
        if (m_act[i]) begin
          if (ev && ew == i) begin
            m_age[i] = 0; m_has[i] = 0;
            if (m_kind[i] == 0) begin m_pend[i][m_dst[i]] = 1; q_w.push_back(i); q_r.push_back(m_dst[i]); end
            else if (m_kind[i] == 2) m_bar[i] = 1;
            else if (m_kind[i] == 3) m_act[i] = 0;
          end else if (m_age[i] < AGE_MAX) m_age[i]++;
          if (rl[i]) m_bar[i] = 0;
        end
      end
      if (ld_valid && int'(ld_warp) == i) begin
        m_has[i] = 1; m_sa[i] = int'(ld_src_a); m_sb[i] = int'(ld_src_b);
        m_dst[i] = int'(ld_dst); m_kind[i] = int'(ld_kind);
      end
    end
    if (ev) m_rr = (ew + 1) % NW;
  endtask

  // Called just after a falling edge with inputs already set.
  task automatic step(string req);
    bit ev; int ew;
    model_pick(ev, ew);
    chk(issue_valid === ev, req, "issue_valid", int'(issue_valid), int'(ev));
    if (ev && issue_valid === 1'b1) begin
      chk(int'(issue_warp) == ew, req, "issue_warp", int'(issue_warp), ew);
      chk(int'(issue_kind) == m_kind[ew], req, "issue_kind", int'(issue_kind), m_kind[ew]);
      if (m_kind[ew] == 0) chk(int'(issue_dst) == m_dst[ew], req, "issue_dst", int'(issue_dst), m_dst[ew]);
    end
    @(posedge clk);
    model_update(ev, ew);
    @(negedge clk);
    launch_valid = 0; ld_valid = 0; wb_valid = 0;
  endtask

  task automatic do_launch(int w, int b);
    launch_valid = 1; launch_warp = 4'(w); launch_block = 2'(b);
  endtask
  task automatic do_load(int w, int a, int b, int d, int k);
    ld_valid = 1; ld_warp = 4'(w); ld_src_a = 4'(a); ld_src_b = 4'(b); ld_dst = 4'(d); ld_kind = 2'(k);
  endtask
  task automatic do_wb(int w, int r);
    wb_valid = 1; wb_warp = 4'(w); wb_reg = 4'(r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) begin
      m_act[i] = 0; m_has[i] = 0; m_bar[i] = 0; m_age[i] = 0; m_blk[i] = 0;
      m_sa[i] = 0; m_sb[i] = 0; m_dst[i] = 0; m_kind[i] = 0;
      for (int r = 0; r < NR; r++) m_pend[i][r] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, load to an unlaunched warp
    repeat (3) step("R1");
    do_load(5, 0, 0, 0, 1); step("R1");
    step("R1");
    // R2: launch clears the held instruction
    do_launch(5, 1); step("R2");
    repeat (2) step("R2");
    // R4: scoreboard set, stall, writeback clears without bypass
    do_load(5, 1, 2, 3, 0); step("R4");
    step("R4");
    do_load(5, 3, 4, 6, 0); step("R4");
    repeat (3) step("R4");
    do_wb(5, 3); step("R4");
    repeat (2) step("R4");
    // R4: same-cycle issue and writeback of one register, the set wins
    do_load(5, 7, 7, 6, 0); step("R4");
    do_wb(5, 6); step("R4");
    do_load(5, 6, 0, 0, 1); step("R4");
    repeat (4) step("R4");
    do_wb(5, 6); step("R4");
    repeat (3) step("R4");
    // R6 and R9: two warps released together, the earlier arrival wins
    do_launch(0, 2); step("R6");
    do_launch(1, 2); step("R6");
    do_load(0, 0, 0, 0, 2); step("R9");
    step("R9");
    do_load(0, 0, 0, 0, 1); step("R9");
    repeat (3) step("R9");
    do_load(1, 0, 0, 0, 2); step("R9");
    step("R9");
    do_load(1, 0, 0, 0, 1); step("R9");
    repeat (4) step("R6");
    // R7 and R8: saturated ages tie, round-robin orders the release
    do_launch(8, 3); step("R8");
    do_launch(10, 3); step("R8");
    do_launch(12, 3); step("R8");
    do_launch(9, 3); step("R8");
    do_load(8, 0, 0, 0, 2); step("R9");
    do_load(10, 0, 0, 0, 2); step("R9");
    do_load(12, 0, 0, 0, 2); step("R9");
    do_load(8, 0, 0, 0, 1); step("R9");
    do_load(10, 0, 0, 0, 1); step("R9");
    do_load(12, 0, 0, 0, 1); step("R9");
    repeat (300) step("R8");
    do_load(9, 0, 0, 0, 2); step("R7");
    repeat (6) step("R7");
    // R10: exit retires the warp, a later load cannot revive it
    do_load(12, 0, 0, 0, 3); step("R10");
    step("R10");
    do_load(12, 0, 0, 0, 1); step("R10");
    repeat (3) step("R10");
    // R11: reload in the issuing cycle keeps the new instruction
    do_load(10, 0, 0, 0, 1); step("R11");
    do_load(10, 0, 0, 0, 1); step("R11");
    repeat (3) step("R11");
    // R3: long random run against the model
    for (int n = 0; n < 5000; n++) begin
      bit ev; int ew; int w, lw;
      model_pick(ev, ew);
      w = $urandom_range(NW - 1);
      lw = -1;
      if ($urandom_range(19) == 0) begin
        lw = $urandom_range(NW - 1);
        if (!m_act[lw]) do_launch(lw, $urandom_range(3)); else lw = -1;
      end
      if (w != lw && (!m_has[w] || (ev && ew == w)) && $urandom_range(1) == 0) begin
        int k = $urandom_range(9);
        do_load(w, $urandom_range(7), $urandom_range(7), $urandom_range(7),
                (k < 5) ? 0 : (k < 7) ? 1 : (k < 9) ? 2 : 3);
      end
      if (q_w.size() > 0 && $urandom_range(2) == 0) begin
        int p = $urandom_range(q_w.size() - 1);
        do_wb(q_w[p], q_r[p]);
        q_w.delete(p); q_r.delete(p);
      end
      step("R3");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule